// File: doc/BRIEF.md
# Escalating Watchdog Timer

This block is a free-running watchdog counter clocked by the 32.768 kHz low-speed clock. Software chooses one of four timeout lengths with a 2-bit code and must pulse a kick input before the count reaches the chosen length. If it does not, the block escalates in two stages. The first missed deadline pulses a non-maskable interrupt so that firmware gets a last chance to recover. A second consecutive missed deadline raises a system reset request, and that request stays raised until the block itself is reset.

The counter has no stop or enable control. Once out of reset it always runs, and a kick is the only way to hold off escalation. A new timeout code takes effect only when a kick captures it, so a stray write to the select lines cannot shorten or stretch the deadline that is already running.

Control is a three-state machine. `WD_ARMED` is the normal state. The transition `WARN` (an overflow in `WD_ARMED`) moves it to `WD_WARNED` and pulses the interrupt. The transition `TRIP` (an overflow in `WD_WARNED`) moves it to `WD_TRIPPED`. The transition `SERVICE` (a kick in `WD_WARNED`) returns it to `WD_ARMED`. `WD_TRIPPED` is left only through reset.

Top module: `watchdog_escalator`

## Requirements
- R1: While `rst_n` is low and right after it is released, `nmi` and `reset_req` are 0 and the active timeout code is 0, whatever `period_sel` holds.
- R2: The timeout length for code k (0 to 3) is 2^(BASE_LOG2+2k) clock cycles. The default BASE_LOG2 of 12 gives 4096, 16384, 65536 and 262144 cycles, which are 125 ms, 500 ms, 2 s and 8 s at 32.768 kHz.
- R3: With no kick, the first overflow happens on the L-th rising edge after the last kick edge (or after reset release), where L is the active length. `nmi` is 1 for exactly the one cycle that follows that edge.
- R4: A second overflow with no kick between it and the first sets `reset_req` after the 2L-th edge. `nmi` does not pulse for that second overflow.
- R5: A kick sampled on a rising edge restarts the count from zero and returns the state from warned to armed. A kick on the same edge as an overflow wins, so neither output changes.
- R6: `period_sel` is captured only on a kick edge. Changing it at any other time does not alter the running timeout.
- R7: Once set, `reset_req` stays 1 until `rst_n` goes low. Kicks are ignored while it is set, and no further `nmi` pulse is produced.
- R8: Holding `kick` at 1 continuously keeps both `nmi` and `reset_req` at 0 for as long as it is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_lsc | input | 1 | 32.768 kHz low-speed clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_sel | input | 2 | Timeout code 0 to 3, captured on a kick |
| kick | input | 1 | Clear request, sampled on each rising edge |
| nmi | output | 1 | One-cycle non-maskable interrupt pulse on the first overflow |
| reset_req | output | 1 | Sticky system reset request after the second overflow |

## Verification
A wrong count or a wrong captured code shows at the ports as an `nmi` pulse that arrives one or more cycles off from L edges after the kick. The bench therefore checks for silence on the edge just before each expected pulse and for the pulse on the expected edge itself. A state machine that forgets it has been warned delays `reset_req` by a whole period, and one that fails to drop back to armed on a kick raises `reset_req` a full period early. Both of these appear within 2L cycles of the kick. A lost sticky state shows as `reset_req` falling after a kick, within one cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        WD_ARMED   = 2'd0,
        WD_WARNED  = 2'd1,
        WD_TRIPPED = 2'd2
    } wd_state_e;

    // Counter width needed for the longest of NUM_PERIODS lengths
    function automatic int unsigned cnt_width(input int unsigned base_log2,
                                              input int unsigned step_log2,
                                              input int unsigned num_periods);
        return base_log2 + step_log2 * (num_periods - 1);
    endfunction

endpackage

// File: rtl/wdt_period_latch.sv
module wdt_period_latch #(
    parameter int unsigned BASE_LOG2   = 12,
    parameter int unsigned STEP_LOG2   = 2,
    parameter int unsigned NUM_PERIODS = 4,
    localparam int unsigned SEL_W = $clog2(NUM_PERIODS),
    localparam int unsigned CNT_W = wdt_pkg::cnt_width(BASE_LOG2, STEP_LOG2, NUM_PERIODS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [SEL_W-1:0] sel_in,
    output logic [CNT_W-1:0] terminal
);

    logic [SEL_W-1:0] active_sel;
    logic [CNT_W-1:0] term_tab [NUM_PERIODS];

    // Reset selects the shortest length; a capture loads a new code
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_sel <= '0;
        end else if (capture) begin
            active_sel <= sel_in;
        end
    end

    for (genvar g = 0; g < NUM_PERIODS; g++) begin : g_term
        localparam logic [CNT_W:0] LEN = (CNT_W+1)'(1) << (BASE_LOG2 + STEP_LOG2 * g);
        assign term_tab[g] = CNT_W'(LEN - 1'b1);
    end

    assign terminal = term_tab[active_sel];

endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
    parameter int unsigned CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kick,
    input  logic [CNT_W-1:0] terminal,
    output logic             overflow
);

    logic [CNT_W-1:0] count_q;
    logic             at_end;

    assign at_end   = (count_q == terminal);
    // A kick on the terminal edge takes priority over the overflow
    assign overflow = at_end && !kick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (kick || at_end) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdt_escalation_fsm.sv
module wdt_escalation_fsm
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    input  logic overflow,
    output logic nmi,
    output logic reset_req
);

    wd_state_e state_q, state_nx;
    logic      warn_ev;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_ARMED;
        end else begin
            state_q <= state_nx;
        end
    end

    // Transitions WARN, TRIP, SERVICE
    always_comb begin
        state_nx = state_q;
        warn_ev  = 1'b0;
        unique case (state_q)
            WD_ARMED: begin
                if (overflow) begin
                    state_nx = WD_WARNED;
                    warn_ev  = 1'b1;
                end
            end
            WD_WARNED: begin
                if (kick) begin
                    state_nx = WD_ARMED;
                end else if (overflow) begin
                    state_nx = WD_TRIPPED;
                end
            end
            WD_TRIPPED: begin
                state_nx = WD_TRIPPED;
            end
            default: begin
                state_nx = WD_TRIPPED;
            end
        endcase
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi       <= 1'b0;
            reset_req <= 1'b0;
        end else begin
            nmi       <= warn_ev;
            reset_req <= (state_nx == WD_TRIPPED);
        end
    end

endmodule

// File: rtl/watchdog_escalator.sv
module watchdog_escalator #(
    parameter int unsigned BASE_LOG2 = 12,
    localparam int unsigned STEP_LOG2   = 2,
    localparam int unsigned NUM_PERIODS = 4,
    localparam int unsigned CNT_W = wdt_pkg::cnt_width(BASE_LOG2, STEP_LOG2, NUM_PERIODS)
) (
    input  logic       clk_lsc,
    input  logic       rst_n,
    input  logic [1:0] period_sel,
    input  logic       kick,
    output logic       nmi,
    output logic       reset_req
);

    logic [CNT_W-1:0] terminal;
    logic             overflow;

    wdt_period_latch #(
        .BASE_LOG2  (BASE_LOG2),
        .STEP_LOG2  (STEP_LOG2),
        .NUM_PERIODS(NUM_PERIODS)
    ) u_latch (
        .clk     (clk_lsc),
        .rst_n   (rst_n),
        .capture (kick),
        .sel_in  (period_sel),
        .terminal(terminal)
    );

    wdt_tick_counter #(
        .CNT_W(CNT_W)
    ) u_count (
        .clk     (clk_lsc),
        .rst_n   (rst_n),
        .kick    (kick),
        .terminal(terminal),
        .overflow(overflow)
    );

    wdt_escalation_fsm u_fsm (
        .clk      (clk_lsc),
        .rst_n    (rst_n),
        .kick     (kick),
        .overflow (overflow),
        .nmi      (nmi),
        .reset_req(reset_req)
    );

endmodule

// File: rtl/wdt_escalator_checker.sv
module wdt_escalator_checker #(
    parameter int unsigned BASE_LOG2 = 12
) (
    input logic clk_lsc,
    input logic rst_n,
    input logic kick,
    input logic nmi,
    input logic reset_req
);

    localparam int unsigned SW = BASE_LOG2 + 8;
    localparam logic [SW-1:0] MIN_LEN = SW'(1) << BASE_LOG2;

    logic [SW-1:0] since_kick;
    logic          warned_seen;

    always_ff @(posedge clk_lsc or negedge rst_n) begin
        if (!rst_n) begin
            since_kick <= '0;
        end else if (kick) begin
            since_kick <= '0;
        end else if (since_kick != '1) begin
            since_kick <= since_kick + 1'b1;
        end
    end

    always_ff @(posedge clk_lsc or negedge rst_n) begin
        if (!rst_n) begin
            warned_seen <= 1'b0;
        end else if (kick && !reset_req) begin
            warned_seen <= 1'b0;
        end else if (nmi) begin
            warned_seen <= 1'b1;
        end
    end

    AST_NMI_SINGLE_PULSE: assert property (@(posedge clk_lsc) disable iff (!rst_n)
        nmi |=> !nmi); // R3

    AST_NMI_NOT_EARLY: assert property (@(posedge clk_lsc) disable iff (!rst_n)
        nmi |-> since_kick >= MIN_LEN); // R2

    AST_TRIP_AFTER_WARN: assert property (@(posedge clk_lsc) disable iff (!rst_n)
        $rose(reset_req) |-> warned_seen); // R4

    AST_KICK_SUPPRESSES: assert property (@(posedge clk_lsc) disable iff (!rst_n)
        (kick && !reset_req) |=> (!nmi && !reset_req)); // R5

    AST_TRIP_HOLDS: assert property (@(posedge clk_lsc) disable iff (!rst_n)
        reset_req |=> reset_req); // R7

    AST_NO_NMI_WHILE_TRIPPED: assert property (@(posedge clk_lsc) disable iff (!rst_n)
        reset_req |-> !nmi); // R7

endmodule

bind watchdog_escalator wdt_escalator_checker #(.BASE_LOG2(BASE_LOG2)) u_checker (
    .clk_lsc  (clk_lsc),
    .rst_n    (rst_n),
    .kick     (kick),
    .nmi      (nmi),
    .reset_req(reset_req)
);

// File: tb/test_watchdog_escalator.sv
module test_watchdog_escalator;

    localparam int unsigned B  = 3;
    localparam int L0 = 1 << B;
    localparam int L1 = 1 << (B + 2);
    localparam int L2 = 1 << (B + 4);
    localparam int L3 = 1 << (B + 6);

    typedef struct packed {
        logic [1:0] sel;
        logic [15:0] edges;
        logic [1:0] exp_pulses;
        logic       exp_rst;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 16'(L0-1),   2'd0, 1'b0},
        '{2'd0, 16'(L0),     2'd1, 1'b0},
        '{2'd0, 16'(2*L0-1), 2'd1, 1'b0},
        '{2'd0, 16'(2*L0),   2'd1, 1'b1},
        '{2'd1, 16'(L1-1),   2'd0, 1'b0},
        '{2'd1, 16'(L1),     2'd1, 1'b0},
        '{2'd1, 16'(2*L1),   2'd1, 1'b1},
        '{2'd2, 16'(L2-1),   2'd0, 1'b0},
        '{2'd2, 16'(L2),     2'd1, 1'b0},
        '{2'd2, 16'(2*L2),   2'd1, 1'b1},
        '{2'd3, 16'(L3-1),   2'd0, 1'b0},
        '{2'd3, 16'(L3),     2'd1, 1'b0},
        '{2'd3, 16'(2*L3),   2'd1, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] period_sel = 2'd0;
    logic       kick = 1'b0;
    logic       nmi;
    logic       reset_req;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit done = 0;

    always #10 clk = ~clk;

    watchdog_escalator #(.BASE_LOG2(B)) i_watchdog_escalator (
        .clk_lsc  (clk),
        .rst_n    (rst_n),
        .period_sel(period_sel),
        .kick     (kick),
        .nmi      (nmi),
        .reset_req(reset_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        kick  = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        pulses = 0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (nmi) pulses++;
        end
    endtask

    task automatic kick_edge(input logic [1:0] s);
        period_sel = s;
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
        if (nmi) pulses++;
    endtask

    initial begin
        // R1 reset state
        rst_n = 1'b0;
        period_sel = 2'd3;
        repeat (2) @(negedge clk);
        chk("R1 nmi in reset", int'(nmi), 0);
        chk("R1 reset_req in reset", int'(reset_req), 0);

        // Vector table: R2 R3 R4
        for (int v = 0; v < NV; v++) begin
            do_reset();
            kick_edge(VEC[v].sel);
            run(int'(VEC[v].edges));
            chk($sformatf("R2/R3 vec %0d nmi pulses", v), pulses, int'(VEC[v].exp_pulses));
            chk($sformatf("R4 vec %0d reset_req", v), int'(reset_req), int'(VEC[v].exp_rst));
        end

        // R1 default code 0 after reset without a kick
        period_sel = 2'd3;
        do_reset();
        chk("R1 nmi after release", int'(nmi), 0);
        run(L0 - 1);
        chk("R1 no nmi before default length", int'(nmi), 0);
        run(1);
        chk("R1 nmi at default length", int'(nmi), 1);

        // R3 one-cycle pulse
        do_reset();
        kick_edge(2'd0);
        run(L0 - 1);
        chk("R3 nmi one edge early", int'(nmi), 0);
        run(1);
        chk("R3 nmi on overflow edge", int'(nmi), 1);
        run(1);
        chk("R3 nmi drops after one cycle", int'(nmi), 0);

        // R4 no nmi on second overflow
        run(L0 - 1);
        chk("R4 nmi on second overflow", int'(nmi), 0);
        chk("R4 reset_req on second overflow", int'(reset_req), 1);

        // R5 kick in warned state returns to armed
        do_reset();
        kick_edge(2'd0);
        run(L0);
        chk("R5 first warn", pulses, 1);
        kick_edge(2'd0);
        run(L0);
        chk("R5 warn again after service", pulses, 2);
        chk("R5 no trip after service", int'(reset_req), 0);
        run(L0);
        chk("R5 trip after unserviced warn", int'(reset_req), 1);

        // R5 kick on the overflow edge wins
        do_reset();
        kick_edge(2'd0);
        run(L0 - 1);
        kick_edge(2'd0);
        chk("R5 kick on overflow edge suppresses nmi", pulses, 0);
        run(L0 - 1);
        chk("R5 count restarted from zero", pulses, 0);
        run(1);
        chk("R5 overflow after restart", int'(nmi), 1);

        // R6 period_sel captured only on kick
        do_reset();
        kick_edge(2'd0);
        period_sel = 2'd3;
        run(L0);
        chk("R6 select change without kick ignored", int'(nmi), 1);
        kick_edge(2'd3);
        run(L3 - 1);
        chk("R6 new code not early", pulses, 1);
        run(1);
        chk("R6 new code after kick", int'(nmi), 1);

        // R7 sticky reset request
        do_reset();
        kick_edge(2'd0);
        run(2 * L0);
        chk("R7 tripped", int'(reset_req), 1);
        kick_edge(2'd0);
        run(4 * L0);
        chk("R7 reset_req held after kick", int'(reset_req), 1);
        chk("R7 no nmi while tripped", pulses, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R7 reset clears reset_req", int'(reset_req), 0);

        // R8 held kick keeps outputs low
        do_reset();
        kick = 1'b1;
        period_sel = 2'd0;
        run(10 * L0);
        kick = 1'b0;
        chk("R8 held kick no nmi", pulses, 0);
        chk("R8 held kick no trip", int'(reset_req), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule